// File: doc/BRIEF.md
# Two-Key Register Write Gate

This block guards a bank of protected registers against stray writes. It sits between a simple request bus and a register file. Reads always go through. Writes that target the protected window go through only while the gate is open. The gate opens after software writes a first magic word to one key address and then a second magic word to another key address, in that order. Any other value written to either key address shuts the gate again. Software normally relocks by writing zero to both key addresses.

Each request is accepted in a single cycle. All of its effects appear on registered outputs in the next cycle: a qualified write strobe with its address and data, a forwarded read strobe, a read-valid flag, and a one-cycle violation pulse for each dropped protected write. A status bit shows when the gate is open. Read data comes back from the register file through the gate. The gate forces it to zero when the read hit a key address. Writes to addresses that are neither key addresses nor in the protected window pass unchanged.

Top module: `regwr_keygate`

## Requirements
- R1: After synchronous reset the gate is shut: `unlocked_o`, `wr_en_o` and `viol_o` are 0.
- R2: A write of 0x83E70B13 to address 0x6C followed by a write of 0x95A4F1E0 to address 0x70 opens the gate, and `unlocked_o` is 1 in the cycle after the second write.
- R3: While the gate is open, a write to a protected word (0x60, 0x64 or 0x68) produces `wr_en_o`=1 with the request's address and data in the next cycle, and no violation.
- R4: While the gate is not open, a write to a protected word is dropped (`wr_en_o` stays 0), and `viol_o` is high for exactly the next cycle.
- R5: Writing zero to either key address shuts the gate from the next cycle on.
- R6: The gate stays or becomes shut if 0x95A4F1E0 reaches 0x70 without a correct first key just before it, if a wrong value goes to 0x70 after a correct first key, or if only the first key has been written.
- R7: Reads are never blocked. A read of a protected word gives `rd_en_o`=1 and `rvalid_o`=1 in the next cycle, and `rdata_o` carries the stored word whether the gate is open or shut.
- R8: A read of either key address returns `rdata_o`=0 with `rvalid_o`=1, is not forwarded (`rd_en_o`=0), and leaves the gate state unchanged.
- R9: A write to an address that is neither a key address nor in the protected window is forwarded whatever the gate state, with no violation.
- R10: Writing the correct first key while the gate is open shuts it until a correct second key follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address of the request |
| req_wdata_i | input | 32 | Write data |
| ds_rdata_i | input | 32 | Read data from the register file at `rd_addr_o` |
| wr_en_o | output | 1 | Qualified write strobe to the register file |
| wr_addr_o | output | 8 | Address of the qualified write |
| wr_data_o | output | 32 | Data of the qualified write |
| rd_en_o | output | 1 | Forwarded read strobe |
| rd_addr_o | output | 8 | Address of the forwarded read |
| rvalid_o | output | 1 | Read result valid on `rdata_o` |
| rdata_o | output | 32 | Read data, zero for key addresses |
| viol_o | output | 1 | One-cycle pulse for a dropped protected write |
| unlocked_o | output | 1 | Gate open |

## Verification
The hardest condition to reach is the intermediate state, where the first key has been accepted but the second has not. No output shows this state. It can only be inferred from what the next key write does. The stimulus therefore pairs a correct first key with each possible follow-up: a correct second key, a wrong second key, the first key repeated at the wrong address, and a first key written while the gate is already open. After each follow-up it checks the status bit and the result of a protected write, which tells the open state apart from the half-open and shut states.

// File: rtl/keygate_pkg.sv
package keygate_pkg;

  // Unlock sequence position
  typedef enum logic [1:0] {
    GATE_SHUT = 2'd0,
    GATE_HALF = 2'd1,
    GATE_OPEN = 2'd2
  } gate_state_e;

  // Address classification of one request
  typedef struct packed {
    logic kick0;
    logic kick1;
    logic prot;
  } addr_hit_t;

endpackage

// File: rtl/keygate_decode.sv
module keygate_decode
  import keygate_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] KICK0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK1_ADDR = 8'h70,
  parameter logic [ADDR_W-1:0] PROT_BASE  = 8'h60,
  parameter int                PROT_WORDS = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output addr_hit_t         hit_o
);

  localparam int WORD_BYTES = 4;

  logic [PROT_WORDS-1:0] prot_vec;

  // One comparator per protected word
  for (genvar g = 0; g < PROT_WORDS; g++) begin : g_prot
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(int'(PROT_BASE) + WORD_BYTES * g);
    assign prot_vec[g] = (addr_i == WADDR);
  end

  always_comb begin
    hit_o.kick0 = (addr_i == KICK0_ADDR);
    hit_o.kick1 = (addr_i == KICK1_ADDR);
    hit_o.prot  = |prot_vec;
  end

endmodule

// File: rtl/keygate_fsm.sv
module keygate_fsm
  import keygate_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0   = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1   = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid_i,
  input  logic              kick0_i,
  input  logic              kick1_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);

  gate_state_e state_q, state_d;
  logic        open_q;

  always_comb begin
    state_d = state_q;
    if (wr_valid_i) begin
      if (kick0_i) begin
        // Correct first key always restarts the sequence
        state_d = (wdata_i == KEY0) ? GATE_HALF : GATE_SHUT;
      end else if (kick1_i) begin
        state_d = ((wdata_i == KEY1) && (state_q == GATE_HALF)) ? GATE_OPEN : GATE_SHUT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_SHUT;
      open_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      open_q  <= (state_d == GATE_OPEN);
    end
  end

  assign open_o = open_q;

endmodule

// File: rtl/keygate_fwd.sv
module keygate_fwd
  import keygate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  addr_hit_t         hit_i,
  input  logic              open_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rvalid_o,
  output logic              key_rd_o,
  output logic              viol_o
);

  logic is_wr, is_rd, is_key;

  assign is_wr  = valid_i &&  write_i;
  assign is_rd  = valid_i && !write_i;
  assign is_key = hit_i.kick0 || hit_i.kick1;

  // Strobes carry reset
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_o  <= 1'b0;
      viol_o   <= 1'b0;
      rd_en_o  <= 1'b0;
      rvalid_o <= 1'b0;
      key_rd_o <= 1'b0;
    end else begin
      wr_en_o  <= is_wr && !is_key && (!hit_i.prot || open_i);
      viol_o   <= is_wr && hit_i.prot && !open_i;
      rd_en_o  <= is_rd && !is_key;
      rvalid_o <= is_rd;
      key_rd_o <= is_rd && is_key;
    end
  end

  // Address and data paths without reset
  always_ff @(posedge clk) begin
    wr_addr_o <= addr_i;
    wr_data_o <= wdata_i;
    rd_addr_o <= addr_i;
  end

endmodule

// File: rtl/regwr_keygate.sv
module regwr_keygate
  import keygate_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] KICK0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0       = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1       = 32'h95A4F1E0,
  parameter logic [ADDR_W-1:0] PROT_BASE  = 8'h60,
  parameter int                PROT_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ds_rdata_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              viol_o,
  output logic              unlocked_o
);

  addr_hit_t hit;
  logic      gate_open;
  logic      key_rd;

  keygate_decode #(
    .ADDR_W     (ADDR_W),
    .KICK0_ADDR (KICK0_ADDR),
    .KICK1_ADDR (KICK1_ADDR),
    .PROT_BASE  (PROT_BASE),
    .PROT_WORDS (PROT_WORDS)
  ) decode_i (
    .addr_i (req_addr_i),
    .hit_o  (hit)
  );

  keygate_fsm #(
    .DATA_W (DATA_W),
    .KEY0   (KEY0),
    .KEY1   (KEY1)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .wr_valid_i (req_valid_i && req_write_i),
    .kick0_i    (hit.kick0),
    .kick1_i    (hit.kick1),
    .wdata_i    (req_wdata_i),
    .open_o     (gate_open)
  );

  keygate_fwd #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) fwd_i (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .hit_i     (hit),
    .open_i    (gate_open),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .rvalid_o  (rvalid_o),
    .key_rd_o  (key_rd),
    .viol_o    (viol_o)
  );

  // Key registers read back as zero
  assign rdata_o    = key_rd ? '0 : ds_rdata_i;
  assign unlocked_o = gate_open;

endmodule

// File: rtl/keygate_chk.sv
module keygate_chk #(
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 32,
  parameter logic [ADDR_W-1:0] KICK0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KICK1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY1       = 32'h95A4F1E0,
  parameter logic [ADDR_W-1:0] PROT_BASE  = 8'h60,
  parameter int                PROT_WORDS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              rd_en_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              viol_o,
  input logic              unlocked_o
);

  localparam int WIN_END = int'(PROT_BASE) + 4 * PROT_WORDS;

  logic in_win, key_addr, wr_prot, rd_prot, rd_key, wr_key_zero;

  assign in_win      = (int'(req_addr_i) >= int'(PROT_BASE)) && (int'(req_addr_i) < WIN_END)
                       && (req_addr_i[1:0] == 2'b00);
  assign key_addr    = (req_addr_i == KICK0_ADDR) || (req_addr_i == KICK1_ADDR);
  assign wr_prot     = req_valid_i && req_write_i && in_win;
  assign rd_prot     = req_valid_i && !req_write_i && in_win;
  assign rd_key      = req_valid_i && !req_write_i && key_addr;
  assign wr_key_zero = req_valid_i && req_write_i && key_addr && (req_wdata_i == '0);

  // R1
  a_r1_reset_shut: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!unlocked_o && !wr_en_o && !viol_o));

  // R2
  a_r2_open_after_key1: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked_o) |-> $past(req_valid_i && req_write_i && (req_addr_i == KICK1_ADDR)
                                && (req_wdata_i == KEY1)));

  // R3
  a_r3_open_forwards: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_prot && unlocked_o)) |->
      (wr_en_o && (wr_addr_o == $past(req_addr_i)) && (wr_data_o == $past(req_wdata_i))));

  // R4
  a_r4_shut_drops: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_prot && !unlocked_o)) |-> (viol_o && !wr_en_o));

  // R4
  a_r4_viol_needs_prot: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && viol_o) |-> $past(wr_prot));

  // R5
  a_r5_zero_relocks: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_key_zero)) |-> !unlocked_o);

  // R7
  a_r7_read_passes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_prot)) |-> rd_en_o);

  // R8
  a_r8_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_key)) |-> (!rd_en_o && (rdata_o == '0) && $stable(unlocked_o)));

endmodule

bind regwr_keygate keygate_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .KICK0_ADDR (KICK0_ADDR),
  .KICK1_ADDR (KICK1_ADDR),
  .KEY1       (KEY1),
  .PROT_BASE  (PROT_BASE),
  .PROT_WORDS (PROT_WORDS)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .req_wdata_i (req_wdata_i),
  .wr_en_o     (wr_en_o),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .rd_en_o     (rd_en_o),
  .rdata_o     (rdata_o),
  .viol_o      (viol_o),
  .unlocked_o  (unlocked_o)
);

// File: tb/regwr_keygate_tb.sv
`timescale 1ns/1ps
module regwr_keygate_tb_top;

  localparam logic [7:0]  A_K0 = 8'h6C;
  localparam logic [7:0]  A_K1 = 8'h70;
  localparam logic [31:0] KEY0 = 32'h83E70B13;
  localparam logic [31:0] KEY1 = 32'h95A4F1E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr  = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] ds_rdata;
  logic        wr_en, rd_en, rvalid, viol, unlocked;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  regwr_keygate dut_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .ds_rdata_i  (ds_rdata),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .rvalid_o    (rvalid),
    .rdata_o     (rdata),
    .viol_o      (viol),
    .unlocked_o  (unlocked)
  );

  // Protected register model: three words at 0x60, 0x64, 0x68
  logic [31:0] scratch [3];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) scratch[i] <= '0;
    end else if (wr_en && wr_addr >= 8'h60 && wr_addr <= 8'h68) begin
      scratch[(wr_addr - 8'h60) >> 2] <= wr_data;
    end
  end
  assign ds_rdata = (rd_addr >= 8'h60 && rd_addr <= 8'h68) ? scratch[(rd_addr - 8'h60) >> 2] : 32'h0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, act, exp);
  endtask

  // Drive one request; returns at the negedge after the accepting edge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_unlock();
    bus_wr(A_K0, KEY0);
    bus_wr(A_K1, KEY1);
  endtask

  task automatic t_reset();
    check_eq("R1 unlocked", {31'b0, unlocked}, 32'd0);
    check_eq("R1 wr_en", {31'b0, wr_en}, 32'd0);
    check_eq("R1 viol", {31'b0, viol}, 32'd0);
  endtask

  task automatic t_locked_drop();
    bus_wr(8'h64, 32'hA5A5A5A5);
    check_eq("R4 wr_en dropped", {31'b0, wr_en}, 32'd0);
    check_eq("R4 viol pulse", {31'b0, viol}, 32'd1);
    idle();
    check_eq("R4 viol one cycle", {31'b0, viol}, 32'd0);
    bus_rd(8'h64);
    check_eq("R7 rd_en while shut", {31'b0, rd_en}, 32'd1);
    check_eq("R7 rvalid", {31'b0, rvalid}, 32'd1);
    check_eq("R4 nothing stored", rdata, 32'h0);
  endtask

  task automatic t_unlock();
    bus_wr(A_K0, KEY0);
    check_eq("R6 first key alone", {31'b0, unlocked}, 32'd0);
    bus_wr(A_K1, KEY1);
    check_eq("R2 open", {31'b0, unlocked}, 32'd1);
  endtask

  task automatic t_open_write();
    bus_wr(8'h60, 32'h11112222);
    check_eq("R3 wr_en", {31'b0, wr_en}, 32'd1);
    check_eq("R3 wr_addr", {24'b0, wr_addr}, 32'h60);
    check_eq("R3 wr_data", wr_data, 32'h11112222);
    check_eq("R3 no viol", {31'b0, viol}, 32'd0);
    bus_wr(8'h68, 32'hDEADBEEF);
    check_eq("R3 wr_data last word", wr_data, 32'hDEADBEEF);
    idle();
    bus_rd(8'h60);
    check_eq("R7 read open 0x60", rdata, 32'h11112222);
    bus_rd(8'h68);
    check_eq("R7 read open 0x68", rdata, 32'hDEADBEEF);
  endtask

  task automatic t_key_read();
    bus_rd(A_K0);
    check_eq("R8 kick0 reads zero", rdata, 32'h0);
    check_eq("R8 not forwarded", {31'b0, rd_en}, 32'd0);
    check_eq("R8 rvalid", {31'b0, rvalid}, 32'd1);
    bus_rd(A_K1);
    check_eq("R8 kick1 reads zero", rdata, 32'h0);
    check_eq("R8 state kept", {31'b0, unlocked}, 32'd1);
  endtask

  task automatic t_relock();
    bus_wr(A_K0, 32'h0);
    check_eq("R5 zero to kick0", {31'b0, unlocked}, 32'd0);
    bus_wr(A_K1, 32'h0);
    check_eq("R5 zero to kick1", {31'b0, unlocked}, 32'd0);
    bus_wr(8'h60, 32'h99999999);
    check_eq("R4 drop after relock", {31'b0, wr_en}, 32'd0);
    check_eq("R4 viol after relock", {31'b0, viol}, 32'd1);
    idle();
    bus_rd(8'h60);
    check_eq("R7 read shut keeps word", rdata, 32'h11112222);
    do_unlock();
    bus_wr(A_K1, 32'h0);
    check_eq("R5 zero to kick1 alone", {31'b0, unlocked}, 32'd0);
  endtask

  task automatic t_bad_order();
    bus_wr(A_K1, KEY1);
    check_eq("R6 key1 without key0", {31'b0, unlocked}, 32'd0);
    bus_wr(A_K0, KEY0);
    bus_wr(A_K1, 32'h12345678);
    check_eq("R6 wrong second key", {31'b0, unlocked}, 32'd0);
    bus_wr(A_K1, KEY1);
    check_eq("R6 retry after wrong second", {31'b0, unlocked}, 32'd0);
    bus_wr(A_K0, KEY0);
    bus_wr(A_K0, KEY1);
    bus_wr(A_K1, KEY1);
    check_eq("R6 wrong value at kick0", {31'b0, unlocked}, 32'd0);
    bus_wr(A_K0, KEY0);
    bus_wr(8'h64, 32'h5555AAAA);
    check_eq("R6 half state blocks write", {31'b0, viol}, 32'd1);
  endtask

  task automatic t_other_addr();
    bus_wr(A_K0, 32'h0);
    bus_wr(8'h40, 32'hCAFEF00D);
    check_eq("R9 wr_en while shut", {31'b0, wr_en}, 32'd1);
    check_eq("R9 addr", {24'b0, wr_addr}, 32'h40);
    check_eq("R9 no viol", {31'b0, viol}, 32'd0);
  endtask

  task automatic t_rekey();
    do_unlock();
    check_eq("R10 open before rekey", {31'b0, unlocked}, 32'd1);
    bus_wr(A_K0, KEY0);
    check_eq("R10 first key shuts", {31'b0, unlocked}, 32'd0);
    bus_wr(8'h64, 32'h77777777);
    check_eq("R10 write dropped in half", {31'b0, wr_en}, 32'd0);
    bus_wr(A_K1, KEY1);
    check_eq("R10 reopened", {31'b0, unlocked}, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle();
    t_reset();
    t_locked_drop();
    t_unlock();
    t_open_write();
    t_key_read();
    t_relock();
    t_bad_order();
    t_other_addr();
    t_rekey();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule